// File: doc/BRIEF.md
# Three-Tone Sine Test Generator

This block produces three digital sinusoids for on-chip analog measurement. The first is a stimulus tone for an external converter that drives the circuit being measured. The other two are a cosine and sine reference pair for a correlating response analyzer. Each of the three oscillators has a phase accumulator with its own frequency word and its own initial phase word. All three read one full-period sine table. The table is shared in time: a fixed three-cycle round visits the stimulus oscillator first, then the cosine reference, then the sine reference.

A frequency-response sweep programs all three oscillators to one frequency. The references then give in-phase and quadrature products of the response. A noise measurement keeps the stimulus at one frequency and moves the reference pair to a second, independent frequency. Words are written through a small write-only port. A write takes effect at a round boundary, so a sample never mixes old and new settings. A synchronous clear returns every accumulator to zero, which puts each tone at its initial phase word. This keeps the references phase-aligned.

Top module: `tg_tone_gen`

## Requirements
- R1: Once per three-cycle round, each oscillator's accumulator advances by its frequency word, modulo 2^PHASE_W (default 24). A tone's frequency is therefore f·(fclk/3)/2^PHASE_W.
- R2: An oscillator's table index is the top LUT_AW bits (default 8) of the accumulator plus its initial phase word, modulo 2^PHASE_W.
- R3: Table entry i holds round(127·sin(2πi/256)) as an 8-bit signed two's-complement value.
- R4: tone_stim takes the entry at oscillator 0's index. tone_ref_sin takes the entry at oscillator 2's index. tone_ref_cos takes the entry at oscillator 1's index plus 64, modulo 256 (a quarter cycle).
- R5: All three outputs update together. tone_stb is high for exactly the one cycle after each update, and strobes come exactly 3 cycles apart. Between strobes the outputs hold.
- R6: cfg_addr[2] selects the word type: 0 is the frequency word, 1 is the initial phase word. cfg_addr[1:0] selects the oscillator: 0 is the stimulus, 1 the cosine reference, 2 the sine reference. A write with cfg_addr[1:0]=3 changes nothing.
- R7: A write accepted in a strobe cycle, or in the cycle right after it, first shows in the samples two strobes later and never in the next strobe's samples. This holds also when the write lands on the round-boundary edge.
- R8: A sync_clr pulse accepted in a strobe cycle, or in the cycle after it, makes the samples two strobes later use zero accumulators. Later samples advance from zero.
- R9: While rst is high, all outputs and tone_stb are 0. All words and accumulators reset to zero, so the first samples are stim 0, cos 127 and sin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Word write strobe |
| cfg_addr | input | 3 | Word select: bit 2 selects frequency or phase, bits 1:0 select the oscillator |
| cfg_wdata | input | PHASE_W | Word value |
| sync_clr | input | 1 | Zero all accumulators at the next round boundary |
| tone_stim | output | SAMPLE_W | Stimulus sample, signed |
| tone_ref_cos | output | SAMPLE_W | In-phase (cosine) reference sample, signed |
| tone_ref_sin | output | SAMPLE_W | Quadrature (sine) reference sample, signed |
| tone_stb | output | 1 | One-cycle pulse when new samples appear |

## Verification
Two things can fall on the same clock edge: a register write or clear, and the round-boundary transfer of shadow words into the active words. The bench provokes this by issuing a second write, or a clear, in the cycle right after a strobe, which is the last cycle of the round. It judges the result against a behavioural model that advances one round per strobe and folds every write made since the previous strobe into the next round's words. A write that the transfer misses shows up as a wrong sample two strobes later.

// File: rtl/tg_pkg.sv
package tg_pkg;

    localparam int NUM_OSC = 3;

    // Round slots in table access order; IDLE marks "no read in flight"
    typedef enum logic [1:0] {
        SLOT_STIM = 2'd0,
        SLOT_COS  = 2'd1,
        SLOT_SIN  = 2'd2,
        SLOT_IDLE = 2'd3
    } slot_e;

    // Decoded word-select field of the write port
    typedef struct packed {
        logic       is_phase;
        logic [1:0] osc;
    } cfg_sel_t;

    // Rounded sine sample for a table of 'entries' points and peak 'amp'
    function automatic int sine_point(input int idx, input int entries, input int amp);
        real ang;
        real v;
        ang = 6.283185307179586 * real'(idx) / real'(entries);
        v   = real'(amp) * $sin(ang);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/tg_sequencer.sv
module tg_sequencer
    import tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output slot_e slot_d,
    output logic  boundary
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= SLOT_STIM;
            slot_d <= SLOT_IDLE;
        end else begin
            case (slot)
                SLOT_STIM: slot <= SLOT_COS;
                SLOT_COS:  slot <= SLOT_SIN;
                default:   slot <= SLOT_STIM;
            endcase
            slot_d <= slot;
        end
    end

    assign boundary = (slot == SLOT_SIN);

endmodule

// File: rtl/tg_word_bank.sv
module tg_word_bank
    import tg_pkg::*;
#(
    parameter int PHASE_W = 24
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             boundary,
    input  logic                             cfg_we,
    input  logic [2:0]                       cfg_addr,
    input  logic [PHASE_W-1:0]               cfg_wdata,
    input  logic                             sync_clr,
    output logic [NUM_OSC-1:0][PHASE_W-1:0]  freq_act,
    output logic [NUM_OSC-1:0][PHASE_W-1:0]  phase_act,
    output logic                             clr_eff
);

    cfg_sel_t sel;
    logic [NUM_OSC-1:0][PHASE_W-1:0] freq_sh, phase_sh, freq_nx, phase_nx;
    logic clr_pend;

    assign sel = cfg_sel_t'(cfg_addr);

    // A write on the boundary edge is bypassed straight into the active copy
    for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
        logic hit;
        assign hit        = cfg_we && (sel.osc == 2'(k));
        assign freq_nx[k]  = (hit && !sel.is_phase) ? cfg_wdata : freq_sh[k];
        assign phase_nx[k] = (hit &&  sel.is_phase) ? cfg_wdata : phase_sh[k];
    end

    assign clr_eff = clr_pend | sync_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_sh   <= '0;
            phase_sh  <= '0;
            freq_act  <= '0;
            phase_act <= '0;
            clr_pend  <= 1'b0;
        end else begin
            freq_sh  <= freq_nx;
            phase_sh <= phase_nx;
            if (boundary) begin
                freq_act  <= freq_nx;
                phase_act <= phase_nx;
                clr_pend  <= 1'b0;
            end else begin
                clr_pend  <= clr_eff;
            end
        end
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(boundary) |-> ($stable(freq_act) && $stable(phase_act))); // R7

endmodule

// File: rtl/tg_phase_accum.sv
module tg_phase_accum
    import tg_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int LUT_AW  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             boundary,
    input  logic                             clr_eff,
    input  logic [NUM_OSC-1:0][PHASE_W-1:0]  freq_act,
    input  logic [NUM_OSC-1:0][PHASE_W-1:0]  phase_act,
    input  slot_e                            slot,
    output logic [LUT_AW-1:0]                lut_addr
);

    localparam logic [LUT_AW-1:0] QUARTER = LUT_AW'(1) << (LUT_AW - 2);

    logic [NUM_OSC-1:0][PHASE_W-1:0] acc;
    logic [NUM_OSC-1:0][LUT_AW-1:0]  idx;

    for (genvar k = 0; k < NUM_OSC; k++) begin : g_acc
        logic [PHASE_W-1:0] sum;
        always_ff @(posedge clk) begin
            if (rst)           acc[k] <= '0;
            else if (boundary) acc[k] <= clr_eff ? '0 : acc[k] + freq_act[k];
        end
        assign sum    = acc[k] + phase_act[k];
        assign idx[k] = sum[PHASE_W-1 -: LUT_AW];
    end

    always_comb begin
        case (slot)
            SLOT_COS: lut_addr = idx[1] + QUARTER;
            SLOT_SIN: lut_addr = idx[2];
            default:  lut_addr = idx[0];
        endcase
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(boundary) |-> $stable(acc)); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(boundary && clr_eff) |-> (acc == '0)); // R8

endmodule

// File: rtl/tg_sine_rom.sv
module tg_sine_rom
    import tg_pkg::*;
#(
    parameter int LUT_AW   = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic [LUT_AW-1:0]          addr,
    output logic signed [SAMPLE_W-1:0] q
);

    localparam int DEPTH = 1 << LUT_AW;
    localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

    logic signed [SAMPLE_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = SAMPLE_W'(sine_point(i, DEPTH, AMP));
    end

    always_ff @(posedge clk) q <= mem[addr];

endmodule

// File: rtl/tg_tone_gen.sv
module tg_tone_gen
    import tg_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int LUT_AW   = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_addr,
    input  logic [PHASE_W-1:0]         cfg_wdata,
    input  logic                       sync_clr,
    output logic signed [SAMPLE_W-1:0] tone_stim,
    output logic signed [SAMPLE_W-1:0] tone_ref_cos,
    output logic signed [SAMPLE_W-1:0] tone_ref_sin,
    output logic                       tone_stb
);

    slot_e slot, slot_d;
    logic  boundary, clr_eff;
    logic [NUM_OSC-1:0][PHASE_W-1:0] freq_act, phase_act;
    logic [LUT_AW-1:0] lut_addr;
    logic signed [SAMPLE_W-1:0] rom_q, hold_stim, hold_cos;

    tg_sequencer u_seq (
        .clk(clk), .rst(rst), .slot(slot), .slot_d(slot_d), .boundary(boundary)
    );

    tg_word_bank #(.PHASE_W(PHASE_W)) u_words (
        .clk(clk), .rst(rst), .boundary(boundary),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sync_clr(sync_clr), .freq_act(freq_act), .phase_act(phase_act),
        .clr_eff(clr_eff)
    );

    tg_phase_accum #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW)) u_accum (
        .clk(clk), .rst(rst), .boundary(boundary), .clr_eff(clr_eff),
        .freq_act(freq_act), .phase_act(phase_act), .slot(slot),
        .lut_addr(lut_addr)
    );

    tg_sine_rom #(.LUT_AW(LUT_AW), .SAMPLE_W(SAMPLE_W)) u_rom (
        .clk(clk), .addr(lut_addr), .q(rom_q)
    );

    // Stage the first two reads, publish all three on the last one
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_stim    <= '0;
            hold_cos     <= '0;
            tone_stim    <= '0;
            tone_ref_cos <= '0;
            tone_ref_sin <= '0;
            tone_stb     <= 1'b0;
        end else begin
            tone_stb <= 1'b0;
            case (slot_d)
                SLOT_STIM: hold_stim <= rom_q;
                SLOT_COS:  hold_cos  <= rom_q;
                SLOT_SIN: begin
                    tone_stim    <= hold_stim;
                    tone_ref_cos <= hold_cos;
                    tone_ref_sin <= rom_q;
                    tone_stb     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tone_stb |=> !tone_stb); // R5

    AST_STB_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(tone_stb, 2) |-> !tone_stb); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tone_stb |-> ($stable(tone_stim) && $stable(tone_ref_cos) && $stable(tone_ref_sin))); // R5

endmodule

// File: tb/tg_tone_gen_bench.sv
`timescale 1ns/1ps
module tg_tone_gen_bench;

    localparam int PW    = 24;
    localparam longint MASK = (64'd1 << PW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic sync_clr = 1'b0;
    logic signed [7:0] tone_stim, tone_ref_cos, tone_ref_sin;
    logic tone_stb;

    always #2 clk = ~clk;

    tg_tone_gen u_tg_tone_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sync_clr(sync_clr),
        .tone_stim(tone_stim), .tone_ref_cos(tone_ref_cos),
        .tone_ref_sin(tone_ref_sin), .tone_stb(tone_stb)
    );

    int total = 0;
    int bad   = 0;
    string tag = "R9";

    int lut [256];
    longint m_acc [3], m_f [3], m_ph [3], s_f [3], s_ph [3];
    bit m_clr = 0;
    bit seen_stb = 0;
    bit had_stb  = 0;
    int gap = 0;
    int p_stim, p_cos, p_sin;

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int idx_of(input int k);
        return int'(((m_acc[k] + m_ph[k]) & MASK) >> (PW - 8));
    endfunction

    // One clock: drop one-cycle drives, check timing, compare and step model on strobe
    task automatic tick();
        @(negedge clk);
        cfg_we   = 1'b0;
        sync_clr = 1'b0;
        gap++;
        seen_stb = tone_stb;
        if (tone_stb) begin
            if (had_stb) check("R5 strobe spacing", gap, 3);
            gap = 0;
            had_stb = 1;
            check("R1/R2 stim", int'(tone_stim), lut[idx_of(0)]);
            check("R4 cos ref", int'(tone_ref_cos), lut[(idx_of(1) + 64) % 256]);
            check("R3 sin ref", int'(tone_ref_sin), lut[idx_of(2)]);
            for (int k = 0; k < 3; k++) begin
                m_acc[k] = m_clr ? 0 : ((m_acc[k] + m_f[k]) & MASK);
                m_f[k]   = s_f[k];
                m_ph[k]  = s_ph[k];
            end
            m_clr = 0;
        end else if (had_stb) begin
            check("R5 hold", int'(tone_stim) + 256*int'(tone_ref_cos) + 65536*int'(tone_ref_sin),
                  p_stim + 256*p_cos + 65536*p_sin);
        end
        p_stim = tone_stim; p_cos = tone_ref_cos; p_sin = tone_ref_sin;
    endtask

    task automatic wait_stb();
        do tick(); while (!seen_stb);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) wait_stb();
    endtask

    // R6: bit 2 picks phase, bits 1:0 pick oscillator, index 3 ignored
    task automatic wr(input logic [2:0] a, input longint d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = PW'(d);
        if (a[1:0] != 2'd3) begin
            if (a[2]) s_ph[a[1:0]] = d & MASK;
            else      s_f[a[1:0]]  = d & MASK;
        end
    endtask

    task automatic clr();
        sync_clr = 1'b1; m_clr = 1;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            real v;
            v = 127.0 * $sin(6.283185307179586 * real'(i) / 256.0);
            lut[i] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        end
        for (int k = 0; k < 3; k++) begin
            m_acc[k] = 0; m_f[k] = 0; m_ph[k] = 0; s_f[k] = 0; s_ph[k] = 0;
        end

        // R9 reset state
        repeat (4) begin
            @(negedge clk);
            check("R9 reset stim", int'(tone_stim), 0);
            check("R9 reset cos", int'(tone_ref_cos), 0);
            check("R9 reset sin", int'(tone_ref_sin), 0);
            check("R9 reset strobe", int'(tone_stb), 0);
        end
        rst = 1'b0;
        run(3);

        // Frequency-response style: shared frequency, R1 R2 R6
        tag = "R1 sweep";
        wait_stb(); wr(3'd0, 24'h040000); tick(); wr(3'd4, 24'h200000);
        wait_stb(); wr(3'd1, 24'h040000); tick(); wr(3'd2, 24'h040000);
        wait_stb(); wr(3'd5, 24'h200000); tick(); wr(3'd6, 24'h200000);
        run(30);

        // Noise style: stimulus and reference pair at independent frequencies
        tag = "R1 split";
        wait_stb(); wr(3'd0, 24'h011111); tick(); wr(3'd1, 24'h052345);
        wait_stb(); wr(3'd2, 24'h052345); tick(); wr(3'd6, 24'h0ABCDE);
        run(30);

        // Index 3 is not a word
        tag = "R6 ignored";
        wait_stb(); wr(3'd3, 24'hFFFFFF); tick(); wr(3'd7, 24'hABCDEF);
        run(6);

        // Write alone on the boundary edge
        tag = "R7 boundary write";
        wait_stb(); tick(); wr(3'd0, 24'h0F0F0F);
        wait_stb(); tick(); wr(3'd5, 24'h7A5A5A);
        run(6);

        // Clear in strobe cycle, then on the boundary edge
        tag = "R8 clear";
        wait_stb(); clr();
        run(5);
        wait_stb(); tick(); clr();
        run(5);

        // Table sweep over all 256 indices with frozen accumulators
        tag = "R3 table";
        wait_stb(); wr(3'd0, 0); tick(); wr(3'd1, 0);
        wait_stb(); wr(3'd2, 0); tick(); clr();
        for (int p = 0; p < 64; p++) begin
            wait_stb(); wr(3'd6, longint'(p * 4) << 16);
            tick();     wr(3'd4, longint'(p * 4 + 1) << 16);
            wait_stb(); wr(3'd5, longint'(p * 4 + 2) << 16);
            tick();     wr(3'd4, longint'(p * 4 + 3) << 16);
        end
        run(3);

        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule